// File: doc/BRIEF.md
# Multi-Layer AHB Crossbar Matrix

This block joins four AHB-Lite style requesters (a processor, a DMA engine, a crypto engine and a debug port) to four responders (flash, two SRAM banks and a peripheral block). Each requester has its own private layer into the matrix and sees an ordinary single-requester bus. Each layer decodes the top address bits to choose a responder port. Each responder port has its own arbiter and its own multiplexer. Because of this, requesters that target different responders move data in the same cycle. Only requesters that collide on one responder are put in sequence, and that responder's arbiter decides the order.

Seen as a stream, `htrans[1]` is the valid of an address phase and `hready` is its ready. A requester holds its address and control stable for as long as `hready` is low. An address phase that loses arbitration is still accepted into a holding register on the requester's layer. The requester is then stalled, with `hready` low, until the holding register has been granted and the responder has finished the data phase. On the responder side, `s_hreadyout` is the back-pressure. No new address is put on a port while that port's `s_hreadyout` is low.

The matrix is sparse: the debug requester has no path to the peripheral responder. A hole in the connectivity, or an address region that is not mapped, is answered by a default responder on the requester's own layer.

Top module: `ahb_xbar_matrix`

## Requirements
- R1: During and right after reset, every requester sees `m_hready` high and `m_hresp` low, and no responder port has `s_hsel` high.
- R2: Address bits [31:29] select the responder: 0 is flash (port 0), 1 is SRAM0 (port 1), 2 is SRAM1 (port 2), 3 is the peripheral block (port 3). Values 4 to 7 are unmapped.
- R3: A granted address phase appears on its responder port with `s_hsel` high, and the requester's address, `htrans` (2'b10 means NONSEQ, 2'b00 means IDLE) and write flag are passed through unchanged.
- R4: During a write data phase, a responder port carries the write data of the requester that owns that data phase, including across wait states.
- R5: Read data and the OKAY response (`hresp` 0) of a responder are returned to the requester that owns the data phase.
- R6: Requesters that target different ready responders are all granted in the same cycle. With zero wait states, each transfer completes one cycle after its address is issued.
- R7: When requesters collide on one responder, exactly one is granted per cycle. Each loser sees `hready` low, its address phase is held, and that address phase is replayed once the loser is granted.
- R8: The SRAM0 port uses fixed priority, where the lowest requester index wins, so the processor (index 0) beats the DMA engine (index 1).
- R9: The peripheral port uses round-robin. The search starts at the requester after the one granted last, and after reset it starts at index 0.
- R10: A responder port starts no new address phase while its `s_hreadyout` is low. A held requester is granted in the cycle the current data phase completes.
- R11: A transfer to an unmapped region, or from the debug requester to the peripheral block, gets an ERROR response. That response has `hresp` high for two cycles, with `hready` low in the first cycle and high in the second, and no responder port sees the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_haddr | input | 4x32 | Address, per requester |
| m_htrans | input | 4x2 | Transfer type, per requester (bit 1 set = active) |
| m_hwrite | input | 4 | Write flag, per requester |
| m_hwdata | input | 4x32 | Write data in the data phase, per requester |
| m_hready | output | 4 | Ready returned to each requester |
| m_hrdata | output | 4x32 | Read data returned to each requester |
| m_hresp | output | 4 | Error response to each requester |
| s_hsel | output | 4 | Select, per responder port |
| s_haddr | output | 4x32 | Forwarded address, per responder port |
| s_htrans | output | 4x2 | Forwarded transfer type, per responder port |
| s_hwrite | output | 4 | Forwarded write flag, per responder port |
| s_hwdata | output | 4x32 | Write data of the data-phase owner, per responder port |
| s_hreadyout | input | 4 | Ready from each responder |
| s_hrdata | input | 4x32 | Read data from each responder |
| s_hresp | input | 4 | Error response from each responder |

## Verification
The bench sets up a collision on SRAM0 right after that port has served the processor. A round-robin arbiter placed there by mistake would then pick the DMA engine first. On the peripheral port it lets the DMA engine win alone first, and then makes the processor and the crypto engine collide. A fixed-priority arbiter there would let the processor win and not the crypto engine. A collision behind a responder that inserts two wait states catches a matrix that re-arbitrates in the middle of a data phase, or that replays the held request late: the completion cycles would differ from 3 and 6. Two further cases catch a default responder that answers in one cycle or lets the request through to a port: the sparse hole from debug to the peripheral block, and an unmapped region. Write data is checked at every responder with random wait states. A write-data multiplexer that follows the current grant rather than the owner of the data phase would then deliver the wrong word.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  // number of top address bits used to pick a responder region
  localparam int REGION_BITS = 3;
endpackage

// File: rtl/xbar_arb.sv
module xbar_arb #(
  parameter int NM = 4,
  parameter int MW = 2,
  parameter int RR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req,
  input  logic          adv,
  output logic [NM-1:0] gnt,
  output logic [MW-1:0] gidx
);
  logic [MW-1:0] last;

  always_comb begin
    int   base;
    int   idx;
    logic found;
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    base  = (RR != 0) ? ((int'(last) + 1) % NM) : 0;
    for (int k = 0; k < NM; k++) begin
      idx = (base + k) % NM;
      if (!found && adv && req[idx]) begin
        found    = 1'b1;
        gnt[idx] = 1'b1;
        gidx     = idx[MW-1:0];
      end
    end
  end

  generate
    if (RR != 0) begin : g_rr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last <= MW'(NM - 1);
        else if (|gnt) last <= gidx;
      end
    end else begin : g_fixed
      assign last = '0;
      // R8
      fixed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> ((req & (gnt - NM'(1))) == '0));
    end
  endgenerate

  // R7
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R10
  no_gnt_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> (gnt == '0));
  // R7
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/xbar_layer.sv
module xbar_layer
  import xbar_pkg::*;
#(
  parameter int NS = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2,
  parameter int RB = 3,
  parameter logic [NS-1:0] CONN = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          m_haddr,
  input  logic [1:0]             m_htrans,
  input  logic                   m_hwrite,
  output logic                   m_hready,
  output logic [DW-1:0]          m_hrdata,
  output logic                   m_hresp,
  input  logic [NS-1:0]          s_hreadyout,
  input  logic [NS-1:0][DW-1:0]  s_hrdata,
  input  logic [NS-1:0]          s_hresp,
  output logic                   req_v,
  output logic [SW-1:0]          req_tgt,
  output logic [AW-1:0]          req_addr,
  output logic [1:0]             req_trans,
  output logic                   req_write,
  input  logic                   req_gnt
);
  logic [RB-1:0] region;
  logic          hit;
  logic          live;
  logic          err_go;

  logic          pend_v;
  logic [SW-1:0] pend_tgt;
  logic [AW-1:0] pend_addr;
  logic [1:0]    pend_trans;
  logic          pend_wr;

  logic          dph_v;
  logic          dph_err;
  logic          err_2nd;
  logic [SW-1:0] dph_tgt;
  logic          dph_rdy;

  assign region = m_haddr[AW-1 -: RB];
  assign hit    = (int'(region) < NS) && CONN[region[SW-1:0]];

  assign dph_rdy  = dph_err ? err_2nd : s_hreadyout[dph_tgt];
  assign m_hready = !pend_v && (!dph_v || dph_rdy);
  assign live     = m_htrans[1] && m_hready;
  assign err_go   = live && !hit;

  assign req_v     = pend_v || (live && hit);
  assign req_tgt   = pend_v ? pend_tgt   : region[SW-1:0];
  assign req_addr  = pend_v ? pend_addr  : m_haddr;
  assign req_trans = pend_v ? pend_trans : m_htrans;
  assign req_write = pend_v ? pend_wr    : m_hwrite;

  assign m_hrdata = (dph_v && !dph_err) ? s_hrdata[dph_tgt] : '0;
  assign m_hresp  = dph_v && (dph_err || s_hresp[dph_tgt]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_tgt   <= '0;
      pend_addr  <= '0;
      pend_trans <= TR_IDLE;
      pend_wr    <= 1'b0;
      dph_v      <= 1'b0;
      dph_err    <= 1'b0;
      err_2nd    <= 1'b0;
      dph_tgt    <= '0;
    end else if (req_v && req_gnt) begin
      dph_v   <= 1'b1;
      dph_err <= 1'b0;
      dph_tgt <= req_tgt;
      pend_v  <= 1'b0;
    end else if (req_v) begin
      pend_v     <= 1'b1;
      pend_tgt   <= req_tgt;
      pend_addr  <= req_addr;
      pend_trans <= req_trans;
      pend_wr    <= req_write;
      dph_v      <= 1'b0;
      dph_err    <= 1'b0;
    end else if (err_go) begin
      dph_v   <= 1'b1;
      dph_err <= 1'b1;
      err_2nd <= 1'b0;
    end else if (dph_v && dph_err && !err_2nd) begin
      err_2nd <= 1'b1;
    end else if (m_hready) begin
      dph_v   <= 1'b0;
      dph_err <= 1'b0;
    end
  end

  // R7
  hold_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v && !req_gnt) |=> (req_v && !m_hready && $stable(req_tgt) && $stable(req_addr)));
  // R11
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hresp && !m_hready) |=> (m_hresp && m_hready));
  // R2
  unmapped_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_htrans[1] && m_hready && !hit) |=> (!req_v && m_hresp && !m_hready));
endmodule

// File: rtl/xbar_port.sv
module xbar_port
  import xbar_pkg::*;
#(
  parameter int NM = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MW = 2,
  parameter int RR = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NM-1:0]         req,
  input  logic [NM-1:0][AW-1:0] req_addr,
  input  logic [NM-1:0][1:0]    req_trans,
  input  logic [NM-1:0]         req_write,
  input  logic [NM-1:0][DW-1:0] m_hwdata,
  input  logic                  s_hreadyout,
  output logic [NM-1:0]         gnt,
  output logic                  s_hsel,
  output logic [AW-1:0]         s_haddr,
  output logic [1:0]            s_htrans,
  output logic                  s_hwrite,
  output logic [DW-1:0]         s_hwdata
);
  logic [MW-1:0] gidx;
  logic [MW-1:0] owner;

  xbar_arb #(.NM(NM), .MW(MW), .RR(RR)) arb_i (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .adv  (s_hreadyout),
    .gnt  (gnt),
    .gidx (gidx)
  );

  assign s_hsel   = |gnt;
  assign s_haddr  = s_hsel ? req_addr[gidx]  : '0;
  assign s_htrans = s_hsel ? req_trans[gidx] : TR_IDLE;
  assign s_hwrite = s_hsel && req_write[gidx];
  assign s_hwdata = m_hwdata[owner];

  // data-phase owner follows the address phase that the responder accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      owner <= '0;
    else if (s_hsel) owner <= gidx;
  end

  // R10
  hsel_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_hsel |-> s_hreadyout);
  // R4
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_hreadyout |=> $stable(owner));
  // R3
  sel_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_hsel |-> req[gidx]);
endmodule

// File: rtl/ahb_xbar_matrix.sv
module ahb_xbar_matrix #(
  parameter int NM = 4,
  parameter int NS = 4,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [NM-1:0][NS-1:0] CONN = {4'b0111, 4'b1111, 4'b1111, 4'b1111},
  parameter logic [NS-1:0] RR_MASK = 4'b1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NM-1:0][AW-1:0] m_haddr,
  input  logic [NM-1:0][1:0]    m_htrans,
  input  logic [NM-1:0]         m_hwrite,
  input  logic [NM-1:0][DW-1:0] m_hwdata,
  output logic [NM-1:0]         m_hready,
  output logic [NM-1:0][DW-1:0] m_hrdata,
  output logic [NM-1:0]         m_hresp,
  output logic [NS-1:0]         s_hsel,
  output logic [NS-1:0][AW-1:0] s_haddr,
  output logic [NS-1:0][1:0]    s_htrans,
  output logic [NS-1:0]         s_hwrite,
  output logic [NS-1:0][DW-1:0] s_hwdata,
  input  logic [NS-1:0]         s_hreadyout,
  input  logic [NS-1:0][DW-1:0] s_hrdata,
  input  logic [NS-1:0]         s_hresp
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;
  localparam int RB = xbar_pkg::REGION_BITS;

  logic [NM-1:0]          req_v;
  logic [NM-1:0][SW-1:0]  req_tgt;
  logic [NM-1:0][AW-1:0]  req_addr;
  logic [NM-1:0][1:0]     req_trans;
  logic [NM-1:0]          req_write;
  logic [NM-1:0]          req_gnt;
  logic [NS-1:0][NM-1:0]  port_req;
  logic [NS-1:0][NM-1:0]  port_gnt;

  generate
    for (genvar m = 0; m < NM; m++) begin : g_layer
      xbar_layer #(
        .NS(NS), .AW(AW), .DW(DW), .SW(SW), .RB(RB), .CONN(CONN[m])
      ) layer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_haddr    (m_haddr[m]),
        .m_htrans   (m_htrans[m]),
        .m_hwrite   (m_hwrite[m]),
        .m_hready   (m_hready[m]),
        .m_hrdata   (m_hrdata[m]),
        .m_hresp    (m_hresp[m]),
        .s_hreadyout(s_hreadyout),
        .s_hrdata   (s_hrdata),
        .s_hresp    (s_hresp),
        .req_v      (req_v[m]),
        .req_tgt    (req_tgt[m]),
        .req_addr   (req_addr[m]),
        .req_trans  (req_trans[m]),
        .req_write  (req_write[m]),
        .req_gnt    (req_gnt[m])
      );

      for (genvar s = 0; s < NS; s++) begin : g_route
        // sparse matrix: absent paths never raise a request at the port
        if (CONN[m][s]) begin : g_path
          assign port_req[s][m] = req_v[m] && (req_tgt[m] == SW'(s));
        end else begin : g_hole
          assign port_req[s][m] = 1'b0;
        end
      end

      // R6
      lone_req_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_v[m] && s_hreadyout[req_tgt[m]] && (port_req[req_tgt[m]] == (NM'(1) << m)))
          |-> req_gnt[m]);
    end

    for (genvar s = 0; s < NS; s++) begin : g_port
      xbar_port #(
        .NM(NM), .AW(AW), .DW(DW), .MW(MW), .RR(int'(RR_MASK[s]))
      ) port_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (port_req[s]),
        .req_addr   (req_addr),
        .req_trans  (req_trans),
        .req_write  (req_write),
        .m_hwdata   (m_hwdata),
        .s_hreadyout(s_hreadyout[s]),
        .gnt        (port_gnt[s]),
        .s_hsel     (s_hsel[s]),
        .s_haddr    (s_haddr[s]),
        .s_htrans   (s_htrans[s]),
        .s_hwrite   (s_hwrite[s]),
        .s_hwdata   (s_hwdata[s])
      );
    end
  endgenerate

  always_comb begin
    for (int m = 0; m < NM; m++) req_gnt[m] = port_gnt[req_tgt[m]][m];
  end
endmodule

// File: tb/ahb_xbar_matrix_tb_top.sv
`timescale 1ns/1ps
module ahb_xbar_matrix_tb_top;
  localparam int NM = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NM-1:0][31:0] m_haddr;
  logic [NM-1:0][1:0]  m_htrans;
  logic [NM-1:0]       m_hwrite;
  logic [NM-1:0][31:0] m_hwdata;
  logic [NM-1:0]       m_hready;
  logic [NM-1:0][31:0] m_hrdata;
  logic [NM-1:0]       m_hresp;
  logic [NS-1:0]       s_hsel;
  logic [NS-1:0][31:0] s_haddr;
  logic [NS-1:0][1:0]  s_htrans;
  logic [NS-1:0]       s_hwrite;
  logic [NS-1:0][31:0] s_hwdata;
  logic [NS-1:0]       s_hreadyout;
  logic [NS-1:0][31:0] s_hrdata;
  logic [NS-1:0]       s_hresp;

  ahb_xbar_matrix dut_i (
    .clk(clk), .rst_n(rst_n),
    .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite), .m_hwdata(m_hwdata),
    .m_hready(m_hready), .m_hrdata(m_hrdata), .m_hresp(m_hresp),
    .s_hsel(s_hsel), .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite),
    .s_hwdata(s_hwdata), .s_hreadyout(s_hreadyout), .s_hrdata(s_hrdata), .s_hresp(s_hresp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] rpat(input int s, input logic [31:0] a);
    return a ^ {8'(s + 1), 24'hC3A55A};
  endfunction
  function automatic logic [31:0] wpat(input logic [31:0] a);
    return ~a ^ 32'h0F1E_2D3C;
  endfunction
  function automatic logic [31:0] mk_addr(input int r, input logic [31:0] low);
    return {r[2:0], low[28:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // responder models: wait states fixed per port (fixw >= 0) or random 0..3
  int          fixw   [NS];
  logic        sl_dph [NS];
  logic        sl_wr  [NS];
  logic [31:0] sl_addr[NS];
  int          sl_wait[NS];
  int          sl_cnt [NS];

  for (genvar g = 0; g < NS; g++) begin : g_sl
    assign s_hreadyout[g] = !(sl_dph[g] && sl_wait[g] != 0);
    assign s_hrdata[g]    = rpat(g, sl_addr[g]);
    assign s_hresp[g]     = 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    for (int s = 0; s < NS; s++) begin
      if (!rst_n) begin
        sl_dph[s] <= 1'b0; sl_wr[s] <= 1'b0; sl_addr[s] <= '0; sl_wait[s] <= 0;
      end else begin
        if (sl_dph[s] && s_hreadyout[s]) begin
          // R4: write data of the data-phase owner reaches the responder
          if (sl_wr[s]) chk(s_hwdata[s] == wpat(sl_addr[s]), "R4 write data", s_hwdata[s], wpat(sl_addr[s]));
          sl_dph[s] <= 1'b0;
        end else if (sl_dph[s]) begin
          sl_wait[s] <= sl_wait[s] - 1;
        end
        if (s_hsel[s] && s_htrans[s][1] && s_hreadyout[s]) begin
          // R3: decoded region matches the port, htrans forwarded as NONSEQ
          chk(int'(s_haddr[s][31:29]) == s && s_htrans[s] == 2'b10, "R3 routed address",
              {s_haddr[s][31:29], 27'd0, s_htrans[s]}, {s[2:0], 27'd0, 2'b10});
          sl_dph[s]  <= 1'b1;
          sl_wr[s]   <= s_hwrite[s];
          sl_addr[s] <= s_haddr[s];
          sl_wait[s] <= (fixw[s] >= 0) ? fixw[s] : int'($urandom_range(0, 3));
          sl_cnt[s]  <= sl_cnt[s] + 1;
        end
      end
    end
  end

  task automatic do_xfer(input int m, input logic [31:0] a, input bit wr,
                         output int lat, output bit rsp, output logic [31:0] rd);
    int st;
    @(negedge clk);
    m_haddr[m] = a; m_htrans[m] = 2'b10; m_hwrite[m] = wr; st = cyc;
    while (!m_hready[m]) @(negedge clk);
    @(negedge clk);
    m_htrans[m] = 2'b00; m_hwdata[m] = wpat(a);
    while (!m_hready[m]) @(negedge clk);
    lat = cyc - st; rsp = m_hresp[m]; rd = m_hrdata[m];
  endtask

  task automatic rnd_run(input int m);
    int l; bit r; logic [31:0] d;
    for (int i = 0; i < 60; i++) begin
      int reg3; logic [31:0] a; bit wr; bit bad;
      reg3 = int'($urandom_range(0, 7));
      a    = mk_addr(reg3, $urandom);
      wr   = 1'($urandom_range(0, 1));
      do_xfer(m, a, wr, l, r, d);
      bad = (reg3 >= 4) || (m == 3 && reg3 == 3);
      if (bad) chk(r == 1'b1 && l == 2, "R11 random error response", {31'd0, r}, 32'd1);
      else begin
        chk(r == 1'b0, "R5 random OKAY response", {31'd0, r}, 32'd0);
        if (!wr) chk(d == rpat(reg3, a), "R5 random read data", d, rpat(reg3, a));
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int l0, l1, l2, l3; bit r0, r1, r2, r3; logic [31:0] d0, d1, d2, d3;
    int c3;
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin fixw[s] = 0; sl_cnt[s] = 0; end
    m_haddr = '0; m_htrans = '0; m_hwrite = '0; m_hwdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(m_hready == 4'hF && m_hresp == 4'h0 && s_hsel == 4'h0, "R1 reset state during reset",
        {20'd0, m_hready, m_hresp, s_hsel}, {20'd0, 4'hF, 4'h0, 4'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_hready == 4'hF && m_hresp == 4'h0 && s_hsel == 4'h0, "R1 reset state after release",
        {20'd0, m_hready, m_hresp, s_hsel}, {20'd0, 4'hF, 4'h0, 4'h0});

    // R6: processor to flash and DMA to SRAM0 in parallel
    fork
      do_xfer(0, mk_addr(0, 32'h100), 1'b0, l0, r0, d0);
      do_xfer(1, mk_addr(1, 32'h200), 1'b1, l1, r1, d1);
    join
    chk(l0 == 1 && l1 == 1, "R6 parallel latency", {l0[15:0], l1[15:0]}, {16'd1, 16'd1});
    chk(d0 == rpat(0, mk_addr(0, 32'h100)) && !r0, "R5 flash read data", d0, rpat(0, mk_addr(0, 32'h100)));

    // R7: both on SRAM1, serialized over the next two cycles
    fork
      do_xfer(0, mk_addr(2, 32'h300), 1'b0, l0, r0, d0);
      do_xfer(1, mk_addr(2, 32'h340), 1'b0, l1, r1, d1);
    join
    chk(l0 == 1 && l1 == 2, "R7 serialized latency", {l0[15:0], l1[15:0]}, {16'd1, 16'd2});
    chk(d1 == rpat(2, mk_addr(2, 32'h340)), "R7 replayed read data", d1, rpat(2, mk_addr(2, 32'h340)));

    // R8: SRAM0 fixed priority, even right after the processor was served there
    do_xfer(0, mk_addr(1, 32'h400), 1'b0, l0, r0, d0);
    fork
      do_xfer(0, mk_addr(1, 32'h410), 1'b1, l0, r0, d0);
      do_xfer(1, mk_addr(1, 32'h420), 1'b1, l1, r1, d1);
    join
    chk(l0 == 1 && l1 == 2, "R8 fixed priority order", {l0[15:0], l1[15:0]}, {16'd1, 16'd2});

    // R9: peripheral round-robin, last grant went to DMA so crypto goes first
    do_xfer(1, mk_addr(3, 32'h500), 1'b0, l1, r1, d1);
    fork
      do_xfer(0, mk_addr(3, 32'h510), 1'b0, l0, r0, d0);
      do_xfer(2, mk_addr(3, 32'h520), 1'b0, l2, r2, d2);
    join
    chk(l2 == 1 && l0 == 2, "R9 round-robin order", {l2[15:0], l0[15:0]}, {16'd1, 16'd2});
    chk(d0 == rpat(3, mk_addr(3, 32'h510)), "R9 read data after loss", d0, rpat(3, mk_addr(3, 32'h510)));

    // R10: two wait states on SRAM1, held request granted when the data phase completes
    fixw[2] = 2;
    fork
      do_xfer(0, mk_addr(2, 32'h600), 1'b1, l0, r0, d0);
      do_xfer(1, mk_addr(2, 32'h640), 1'b0, l1, r1, d1);
    join
    chk(l0 == 3 && l1 == 6, "R10 stall and replay timing", {l0[15:0], l1[15:0]}, {16'd3, 16'd6});
    chk(d1 == rpat(2, mk_addr(2, 32'h640)), "R10 read data after stall", d1, rpat(2, mk_addr(2, 32'h640)));
    fixw[2] = 0;

    // R11: sparse hole debug -> peripheral
    c3 = sl_cnt[3];
    do_xfer(3, mk_addr(3, 32'h700), 1'b0, l3, r3, d3);
    chk(r3 == 1'b1 && l3 == 2, "R11 hole error response", {l3[15:0], 15'd0, r3}, {16'd2, 15'd0, 1'b1});
    @(negedge clk);
    chk(sl_cnt[3] == c3, "R11 peripheral untouched", 32'(sl_cnt[3]), 32'(c3));
    // R2: unmapped region and a mapped debug path
    do_xfer(0, mk_addr(6, 32'h800), 1'b0, l0, r0, d0);
    chk(r0 == 1'b1 && l0 == 2, "R2 unmapped region error", {l0[15:0], 15'd0, r0}, {16'd2, 15'd0, 1'b1});
    do_xfer(3, mk_addr(0, 32'h900), 1'b0, l3, r3, d3);
    chk(r3 == 1'b0 && d3 == rpat(0, mk_addr(0, 32'h900)), "R2 debug to flash", d3, rpat(0, mk_addr(0, 32'h900)));

    // random traffic from all requesters with random wait states
    for (int s = 0; s < NS; s++) fixw[s] = -1;
    fork
      rnd_run(0);
      rnd_run(1);
      rnd_run(2);
      rnd_run(3);
    join
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule